// File: doc/BRIEF.md
# Control-Transfer and Stack Unit

This unit resolves every program-flow change of a small 8-bit processor with a 16-bit address space: plain and conditional jumps, calls and returns, the eight fixed restart entries, the two HL-sourced transfers (jump to HL, copy HL into the stack pointer) and the swap of HL with the word on top of the stack. The decoder gives it a transfer kind, a condition selector, a restart index, the current PC, SP and HL, the four testable flags and the 16-bit operand already fetched. The unit returns the next PC, SP and HL and the extra cycles that the instruction costs.

Calls, returns and the stack swap use a word-wide memory port with a ready handshake. The port stalls the unit until the memory answers. Words on the port are little-endian, so bits [7:0] of a word sit at the lower byte address. `pc_in` is the address that follows the opcode byte. Kinds that carry a two-byte operand therefore fall through to, or return to, `pc_in + 2`.

Results are registered. They are valid in the single cycle in which `done` is high.

Top module: `xfer_stack_unit`

## Requirements
- R1: A push (kinds CALL=2, taken conditional call=3, restart=6) writes one word at address `sp_in - 2`, and `sp_out` becomes `sp_in - 2`.
- R2: A pop (return=4, taken conditional return=5) reads the word at `sp_in`, loads it into `pc_out`, and `sp_out` becomes `sp_in + 2`.
- R3: A call writes `pc_in + 2` as the return address and sets `pc_out` to `target`.
- R4: A conditional jump (kind 1) never touches memory. It gives `pc_out = target` when the condition holds and `pc_in + 2` when it does not. The plain jump (kind 0) always gives `target`.
- R5: The condition selector encodes 0 = Z clear, 1 = Z set, 2 = C clear, 3 = C set, 4 = P clear, 5 = P set, 6 = S clear, 7 = S set. A not-taken conditional call or return leaves SP unchanged and makes no memory request. A not-taken call gives `pc_out = pc_in + 2`, and a not-taken return gives `pc_out = pc_in`.
- R6: `extra_cycles` is 6 for a taken conditional call or return, and 0 for every other transfer.
- R7: Restart n (kind 6, `rst_num` = n) pushes `pc_in` and sets `pc_out` to 8*n.
- R8: Kind 7 sets `pc_out` to `hl_in`. Kind 8 sets `sp_out` to `hl_in` and `pc_out` to `pc_in`. Neither kind issues a memory request.
- R9: Kind 9 reads the word at `sp_in`, then writes `hl_in` to the same address. `hl_out` becomes the word read, and `sp_out` stays at `sp_in`.
- R10: While `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady. `done` rises in the cycle after the final access is accepted and lasts one cycle.
- R11: A `start` that arrives while a memory transfer is still in flight is ignored, and the transfer in flight completes with its own results.
- R12: After reset, `done` and `mem_req` are low. A transfer that needs no memory raises `done` in the cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer using the inputs sampled this cycle |
| kind | input | 4 | Transfer kind, 0..9 |
| cond_code | input | 3 | Condition selector |
| rst_num | input | 3 | Restart index |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_p | input | 1 | Parity flag |
| flag_c | input | 1 | Carry flag |
| pc_in | input | 16 | Address following the opcode byte |
| sp_in | input | 16 | Current stack pointer |
| hl_in | input | 16 | Current HL pair |
| target | input | 16 | Fetched operand address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Word address (low byte first) |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Word read |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| done | output | 1 | Results valid, one cycle |
| pc_out | output | 16 | Next PC |
| sp_out | output | 16 | Next SP |
| hl_out | output | 16 | Next HL |
| extra_cycles | output | 3 | Penalty cycles for a taken conditional call or return |

## Verification
Two events can fall in the same cycle: a stalled memory access in flight and a fresh `start` for a different kind. The bench forces `mem_ready` low for one cycle and pulses `start` with a plain jump toward an unrelated target during that cycle. The stall and the request are then judged at the ports. The pending call, return or swap must still write and read the same addresses and data, and its PC, SP and HL results must match those computed for the original instruction. No second `done` may appear from the ignored request.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int ADDR_W = 16;

  typedef enum logic [3:0] {
    K_JMP   = 4'd0,
    K_JCC   = 4'd1,
    K_CALL  = 4'd2,
    K_CCALL = 4'd3,
    K_RET   = 4'd4,
    K_CRET  = 4'd5,
    K_RST   = 4'd6,
    K_PCHL  = 4'd7,
    K_SPHL  = 4'd8,
    K_XCHG  = 4'd9
  } xfer_kind_e;

  typedef enum logic [1:0] {
    M_NONE = 2'd0,
    M_PUSH = 2'd1,
    M_POP  = 2'd2,
    M_XCHG = 2'd3
  } mem_op_e;
endpackage

// File: rtl/xfer_cond.sv
module xfer_cond (
  input  logic [2:0] cond_code,
  input  logic       flag_s,
  input  logic       flag_z,
  input  logic       flag_p,
  input  logic       flag_c,
  output logic       taken
);
  logic picked;

  // bits [2:1] pick the flag, bit 0 is the polarity required
  always_comb begin
    unique case (cond_code[2:1])
      2'd0: picked = flag_z;
      2'd1: picked = flag_c;
      2'd2: picked = flag_p;
      default: picked = flag_s;
    endcase
    taken = (picked == cond_code[0]);
  end
endmodule

// File: rtl/xfer_plan.sv
module xfer_plan
  import xfer_pkg::*;
#(
  parameter int AW        = ADDR_W,
  parameter int RST_SHIFT = 3,
  parameter int PENALTY   = 6,
  parameter int PEN_W     = $clog2(PENALTY + 1)
) (
  input  xfer_kind_e        kind,
  input  logic              taken,
  input  logic [2:0]        rst_num,
  input  logic [AW-1:0]     pc_in,
  input  logic [AW-1:0]     sp_in,
  input  logic [AW-1:0]     hl_in,
  input  logic [AW-1:0]     target,
  output mem_op_e           op,
  output logic [AW-1:0]     new_pc,
  output logic [AW-1:0]     new_sp,
  output logic [AW-1:0]     push_val,
  output logic [PEN_W-1:0]  extra
);
  localparam logic [AW-1:0] OPND_LEN = AW'(2);
  localparam logic [AW-1:0] WORD_LEN = AW'(2);

  function automatic logic [AW-1:0] skip_operand(input logic [AW-1:0] pc);
    return pc + OPND_LEN;
  endfunction

  function automatic logic [AW-1:0] restart_vec(input logic [2:0] n);
    return AW'(n) << RST_SHIFT;
  endfunction

  always_comb begin
    op       = M_NONE;
    new_pc   = pc_in;
    new_sp   = sp_in;
    push_val = skip_operand(pc_in);
    extra    = '0;
    unique case (kind)
      K_JMP: new_pc = target;
      K_JCC: new_pc = taken ? target : skip_operand(pc_in);
      K_CALL: begin
        op     = M_PUSH;
        new_pc = target;
        new_sp = sp_in - WORD_LEN;
      end
      K_CCALL: begin
        new_pc = skip_operand(pc_in);
        if (taken) begin
          op     = M_PUSH;
          new_pc = target;
          new_sp = sp_in - WORD_LEN;
          extra  = PEN_W'(PENALTY);
        end
      end
      K_RET: begin
        op     = M_POP;
        new_sp = sp_in + WORD_LEN;
      end
      K_CRET: begin
        if (taken) begin
          op     = M_POP;
          new_sp = sp_in + WORD_LEN;
          extra  = PEN_W'(PENALTY);
        end
      end
      K_RST: begin
        op       = M_PUSH;
        new_pc   = restart_vec(rst_num);
        new_sp   = sp_in - WORD_LEN;
        push_val = pc_in;
      end
      K_PCHL: new_pc = hl_in;
      K_SPHL: new_sp = hl_in;
      K_XCHG: op = M_XCHG;
      default: ;
    endcase
  end
endmodule

// File: rtl/xfer_stack_unit.sv
module xfer_stack_unit
  import xfer_pkg::*;
#(
  parameter int AW        = ADDR_W,
  parameter int RST_SHIFT = 3,
  parameter int PENALTY   = 6,
  parameter int PEN_W     = $clog2(PENALTY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       kind,
  input  logic [2:0]       cond_code,
  input  logic [2:0]       rst_num,
  input  logic             flag_s,
  input  logic             flag_z,
  input  logic             flag_p,
  input  logic             flag_c,
  input  logic [AW-1:0]    pc_in,
  input  logic [AW-1:0]    sp_in,
  input  logic [AW-1:0]    hl_in,
  input  logic [AW-1:0]    target,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [AW-1:0]    mem_wdata,
  input  logic [AW-1:0]    mem_rdata,
  input  logic             mem_ready,
  output logic             done,
  output logic [AW-1:0]    pc_out,
  output logic [AW-1:0]    sp_out,
  output logic [AW-1:0]    hl_out,
  output logic [PEN_W-1:0] extra_cycles
);
  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_POP, S_XRD, S_XWR} st_e;

  st_e             st;
  xfer_kind_e      kind_e, kind_q;
  logic            taken;
  mem_op_e         plan_op;
  logic [AW-1:0]   plan_pc, plan_sp, plan_push;
  logic [PEN_W-1:0] plan_extra;
  logic [AW-1:0]   sp_q, hl_q, push_q, swap_q;
  logic            accept, access_done;

  assign kind_e = xfer_kind_e'(kind);

  xfer_cond u_cond (
    .cond_code(cond_code), .flag_s(flag_s), .flag_z(flag_z),
    .flag_p(flag_p), .flag_c(flag_c), .taken(taken)
  );

  xfer_plan #(.AW(AW), .RST_SHIFT(RST_SHIFT), .PENALTY(PENALTY), .PEN_W(PEN_W)) u_plan (
    .kind(kind_e), .taken(taken), .rst_num(rst_num), .pc_in(pc_in),
    .sp_in(sp_in), .hl_in(hl_in), .target(target), .op(plan_op),
    .new_pc(plan_pc), .new_sp(plan_sp), .push_val(plan_push), .extra(plan_extra)
  );

  // named events for the checks below
  assign accept      = start && (st == S_IDLE);
  assign access_done = mem_req && mem_ready;

  always_comb begin
    mem_req   = (st != S_IDLE);
    mem_we    = (st == S_PUSH) || (st == S_XWR);
    mem_addr  = (st == S_PUSH) ? sp_out : sp_q;
    mem_wdata = (st == S_XWR) ? hl_q : push_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      kind_q       <= K_JMP;
      done         <= 1'b0;
      pc_out       <= '0;
      sp_out       <= '0;
      hl_out       <= '0;
      extra_cycles <= '0;
      sp_q         <= '0;
      hl_q         <= '0;
      push_q       <= '0;
      swap_q       <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (accept) begin
          kind_q       <= kind_e;
          pc_out       <= plan_pc;
          sp_out       <= plan_sp;
          hl_out       <= hl_in;
          extra_cycles <= plan_extra;
          sp_q         <= sp_in;
          hl_q         <= hl_in;
          push_q       <= plan_push;
          unique case (plan_op)
            M_PUSH:  st <= S_PUSH;
            M_POP:   st <= S_POP;
            M_XCHG:  st <= S_XRD;
            default: done <= 1'b1;
          endcase
        end
        S_PUSH: if (mem_ready) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        S_POP: if (mem_ready) begin
          pc_out <= mem_rdata;
          st     <= S_IDLE;
          done   <= 1'b1;
        end
        S_XRD: if (mem_ready) begin
          swap_q <= mem_rdata;
          st     <= S_XWR;
        end
        S_XWR: if (mem_ready) begin
          hl_out <= swap_q;
          st     <= S_IDLE;
          done   <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: a push writes one word below the stack pointer seen at start
  p_push_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PUSH) |-> (mem_we && mem_addr == sp_q - AW'(2)));

  // R10: a stalled request holds every field
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9: the swap leaves the stack pointer alone
  p_xchg_sp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind_q == K_XCHG) |-> (sp_out == sp_q));

  // R7: restart targets are aligned vectors in the low page
  p_rst_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind_e == K_RST) |=> (pc_out[RST_SHIFT-1:0] == '0 && pc_out < AW'(8 << RST_SHIFT)));

  // R6: a penalty is reported only by conditional call or return
  p_extra_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && extra_cycles != '0) |-> (kind_q == K_CCALL || kind_q == K_CRET));

  // R11: a start during a transfer does not replace the captured kind
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != S_IDLE && !access_done) |=> $stable(kind_q));
endmodule

// File: tb/xfer_stack_unit_bench.sv
module xfer_stack_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] kind = 4'd0;
  logic [2:0] cond_code = 3'd0, rst_num = 3'd0;
  logic flag_s = 0, flag_z = 0, flag_p = 0, flag_c = 0;
  logic [15:0] pc_in = 0, sp_in = 0, hl_in = 0, target = 0;
  logic mem_req, mem_we, mem_ready = 1'b0, done;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_out, sp_out, hl_out;
  logic [2:0] extra_cycles;

  int n_run = 0, n_fail = 0;
  bit timed_out = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem_addr ^ 16'h5A3C;

  xfer_stack_unit u_xfer_stack_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .cond_code(cond_code),
    .rst_num(rst_num), .flag_s(flag_s), .flag_z(flag_z), .flag_p(flag_p),
    .flag_c(flag_c), .pc_in(pc_in), .sp_in(sp_in), .hl_in(hl_in), .target(target),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done), .pc_out(pc_out),
    .sp_out(sp_out), .hl_out(hl_out), .extra_cycles(extra_cycles)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // condition written as an explicit truth table per selector
  function automatic bit cond_holds(input logic [2:0] cc, input bit s, z, p, c);
    case (cc)
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !c;
      3'd3: return c;
      3'd4: return !p;
      3'd5: return p;
      3'd6: return !s;
      default: return s;
    endcase
  endfunction

  // stall_mode: 0 = random ready, 1 = first cycle stalled, 2 = stall plus stray start
  task automatic run_op(input logic [3:0] k, input logic [2:0] cc, input logic [2:0] rn,
                        input logic [3:0] fl, input logic [15:0] pc, sp, hl, tg,
                        input int stall_mode);
    bit t;
    bit e_push, e_pop, e_swap;
    logic [15:0] e_pc, e_sp, e_hl, e_wdata;
    logic [2:0] e_extra;
    int n_wr = 0, n_rd = 0;
    logic [15:0] w_addr = 0, w_data = 0, r_addr = 0;
    logic [15:0] prev_addr = 0, prev_wdata = 0;
    bit prev_stall = 0, got = 0;
    t = cond_holds(cc, fl[3], fl[2], fl[1], fl[0]);
    e_push = 0; e_pop = 0; e_swap = 0; e_extra = 0;
    e_pc = pc; e_sp = sp; e_hl = hl; e_wdata = pc + 16'd2;
    case (k)
      4'd0: e_pc = tg;
      4'd1: e_pc = t ? tg : pc + 16'd2;
      4'd2: begin e_push = 1; e_pc = tg; e_sp = sp - 16'd2; end
      4'd3: if (t) begin e_push = 1; e_pc = tg; e_sp = sp - 16'd2; e_extra = 3'd6; end
            else e_pc = pc + 16'd2;
      4'd4: begin e_pop = 1; e_pc = sp ^ 16'h5A3C; e_sp = sp + 16'd2; end
      4'd5: if (t) begin e_pop = 1; e_pc = sp ^ 16'h5A3C; e_sp = sp + 16'd2; e_extra = 3'd6; end
      4'd6: begin e_push = 1; e_pc = {10'd0, rn, 3'd0}; e_sp = sp - 16'd2; e_wdata = pc; end
      4'd7: e_pc = hl;
      4'd8: e_sp = hl;
      4'd9: begin e_swap = 1; e_hl = sp ^ 16'h5A3C; e_wdata = hl; end
      default: ;
    endcase
    @(negedge clk);
    kind = k; cond_code = cc; rst_num = rn;
    {flag_s, flag_z, flag_p, flag_c} = fl;
    pc_in = pc; sp_in = sp; hl_in = hl; target = tg;
    start = 1'b1;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      kind = k; target = tg;
      if (done) begin got = 1; break; end
      if (prev_stall) begin
        chk(mem_req && mem_addr == prev_addr && mem_wdata == prev_wdata,
            "R10 stall hold", {mem_addr, mem_wdata}, {prev_addr, prev_wdata});
      end
      mem_ready = ($urandom % 3) != 0;
      if (cyc == 0 && stall_mode != 0) mem_ready = 1'b0;
      if (cyc == 0 && stall_mode == 2 && mem_req) begin
        start = 1'b1; kind = 4'd0; target = 16'hDEAD;   // R11 stray request
      end
      prev_stall = mem_req && !mem_ready;
      prev_addr = mem_addr; prev_wdata = mem_wdata;
      if (mem_req && mem_ready) begin
        if (mem_we) begin n_wr++; w_addr = mem_addr; w_data = mem_wdata; end
        else begin n_rd++; r_addr = mem_addr; end
      end
    end
    mem_ready = 1'b0;
    chk(got, "R10 done reached", got, 1);
    chk(pc_out == e_pc, (k == 4'd6) ? "R7 pc" : (k inside {4'd1, 4'd0}) ? "R4 pc" : "R3/R5 pc", pc_out, e_pc);
    chk(sp_out == e_sp, (k == 4'd8) ? "R8 sp" : "R1/R2 sp", sp_out, e_sp);
    chk(hl_out == e_hl, "R9 hl", hl_out, e_hl);
    chk(extra_cycles == e_extra, "R6 extra", extra_cycles, e_extra);
    chk(n_wr == ((e_push || e_swap) ? 1 : 0), "R5 write count", n_wr, (e_push || e_swap));
    chk(n_rd == ((e_pop || e_swap) ? 1 : 0), "R2 read count", n_rd, (e_pop || e_swap));
    if (e_push) begin
      chk(w_addr == sp - 16'd2, "R1 push addr", w_addr, sp - 16'd2);
      chk(w_data == e_wdata, "R3 return addr", w_data, e_wdata);
    end
    if (e_pop) chk(r_addr == sp, "R2 pop addr", r_addr, sp);
    if (e_swap) begin
      chk(r_addr == sp && w_addr == sp, "R9 swap addr", {r_addr, w_addr}, {sp, sp});
      chk(w_data == hl, "R9 swap data", w_data, hl);
    end
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!done && !mem_req, "R12 reset idle", {done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req, "R12 idle after reset", {done, mem_req}, 0);
    // directed corners
    run_op(4'd2, 3'd0, 3'd0, 4'h0, 16'h1234, 16'h0000, 16'h1111, 16'hABCD, 1); // R1 SP wrap
    run_op(4'd4, 3'd0, 3'd0, 4'h0, 16'h2000, 16'hFFFE, 16'h1111, 16'h0, 1);    // R2 SP wrap
    run_op(4'd1, 3'd3, 3'd0, 4'h1, 16'h0100, 16'h8000, 16'h0, 16'h4444, 0);    // R4 taken
    run_op(4'd1, 3'd3, 3'd0, 4'h0, 16'h0100, 16'h8000, 16'h0, 16'h4444, 0);    // R4 not taken
    run_op(4'd3, 3'd1, 3'd0, 4'h0, 16'h0300, 16'h8000, 16'h0, 16'h5555, 0);    // R5 call skipped
    run_op(4'd5, 3'd7, 3'd0, 4'h0, 16'h0300, 16'h8000, 16'h0, 16'h0, 0);       // R5 return skipped
    run_op(4'd6, 3'd0, 3'd7, 4'h0, 16'h0777, 16'h9000, 16'h0, 16'h0, 0);       // R7 top vector
    run_op(4'd7, 3'd0, 3'd0, 4'h0, 16'h0010, 16'h9000, 16'hBEEF, 16'h0, 0);    // R8
    run_op(4'd8, 3'd0, 3'd0, 4'h0, 16'h0010, 16'h9000, 16'hC0DE, 16'h0, 0);    // R8
    run_op(4'd9, 3'd0, 3'd0, 4'h0, 16'h0010, 16'h7FF0, 16'h1357, 16'h0, 1);    // R9
    run_op(4'd3, 3'd6, 3'd0, 4'h0, 16'h0400, 16'h8800, 16'h0, 16'h6000, 2);    // R11 call
    run_op(4'd9, 3'd0, 3'd0, 4'h0, 16'h0400, 16'h8800, 16'h2468, 16'h0, 2);    // R11 swap
    run_op(4'd5, 3'd4, 3'd0, 4'h0, 16'h0400, 16'h8800, 16'h0, 16'h0, 2);       // R11 return
    for (int i = 0; i < 400; i++) begin
      run_op(4'($urandom % 10), 3'($urandom), 3'($urandom), 4'($urandom),
             16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), int'($urandom % 3));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    timed_out = 1;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule